// File: doc/BRIEF.md
# Return Address Stack Predictor

This block supplies a predicted return target to the fetch stage in the same cycle the fetch address is presented, before the instruction has been decoded. It keeps a small circular stack of return addresses. A decoded call pushes its fall-through address onto the stack, and a decoded return pops it. A small direct-mapped table, tagged by instruction address, records which fetch addresses hold return instructions. When the current fetch address hits in that table and the stack holds at least one live entry, the top of the stack is offered as the predicted target.

The decode stage reports one instruction per cycle as a class code with its PC and branch target. Two patterns are filtered out so they cannot corrupt the stack:
- a register branch through the link register, which is not a return;
- a call whose target is its own fall-through address.

Every prediction exposes the current top-of-stack pointer and live count as a snapshot. When the resolve stage detects a mispredict, it hands a snapshot back and the stack bookkeeping is rewound to it. Calls and returns that do not pair up only cause wrong predictions, never a stall.

Top module: `retStackPredictor`

## Requirements
- R1: A synchronous active-high reset clears the table valid bits, the stack pointer and the live count. After reset, predValid is 0 and predPtr and predCount read 0.
- R2: A decoded call (decClass 1) whose target differs from PC+4 writes PC+4 into the slot after the top. The pointer then advances by one, modulo the depth, and the count grows by one.
- R3: A decoded return (decClass 2) moves the pointer back by one and lowers a nonzero count by one. Nested calls are therefore predicted in last-in, first-out order.
- R4: The table is indexed by PC[5:2] and tagged with PC[31:6]. A decoded return whose PC misses in the table writes that PC's entry, replacing any other tag at the same index. predValid is 1 exactly when the fetch PC hits and the count is nonzero, and predTarget is then the top entry.
- R5: A link-register branch (decClass 3) leaves the pointer and count unchanged and is never recorded in the table.
- R6: A call whose target equals its PC+4 leaves the pointer and count unchanged.
- R7: With 8 live entries, a further push overwrites the oldest slot through the wrapping pointer, and the count stays at 8.
- R8: A return decoded at count 0 wraps the pointer back and keeps the count at 0. predValid stays 0 until the next push.
- R9: When rsvMispredict is 1, the pointer and count take rsvPtr and rsvCount at the next edge. The count is clamped to the depth, and this overrides any decode report in that cycle.
- R10: A return-then-call (decClass 4) applies the pop before the push. The top slot is replaced with PC+4, the pointer is unchanged, and the count becomes the larger of its old value and 1. A missing PC is also recorded in the table as a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchPc | input | 32 | Current fetch address |
| decValid | input | 1 | Decode report valid |
| decClass | input | 3 | 0 other, 1 call, 2 return, 3 link-register branch, 4 return-then-call |
| decPc | input | 32 | PC of the decoded instruction |
| decTarget | input | 32 | Branch target of the decoded instruction |
| rsvMispredict | input | 1 | Resolve stage requests a rewind |
| rsvPtr | input | 3 | Pointer snapshot to restore |
| rsvCount | input | 4 | Count snapshot to restore |
| predValid | output | 1 | Fetch PC is a known return and the stack is not empty |
| predTarget | output | 32 | Predicted return target (top of stack) |
| predPtr | output | 3 | Snapshot: current top-of-stack pointer |
| predCount | output | 4 | Snapshot: current live count |

## Verification
The stimulus interleaves nested calls and returns so that predicted targets must come back in last-in, first-out order. This distinguishes a true stack from a single last-address register. Link-register branches and call-to-next instructions are sent between real calls, which shows whether the filters keep the pointer, count and table untouched. A run of nine calls followed by more returns than pushes exercises both the wrap-around overwrite and the empty-stack suppression. Rewinds issued in the same cycle as a decoded call, and return-then-call reports, separate the correct priority order from its alternatives.

// File: rtl/rasPkg.sv
package rasPkg;

  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_CALL    = 3'd1,
    CLS_RET     = 3'd2,
    CLS_LINKBR  = 3'd3,
    CLS_RETCALL = 3'd4
  } instrClassT;

  typedef struct packed {
    logic push;
    logic pop;
    logic restore;
    logic learn;
  } stackStrobeT;

endpackage

// File: rtl/rasCtrl.sv
module rasCtrl
  import rasPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              decValid,
  input  logic [2:0]        decClass,
  input  logic [ADDR_W-1:0] decPc,
  input  logic [ADDR_W-1:0] decTarget,
  input  logic              rsvMispredict,
  input  logic              decTblHit,
  output stackStrobeT       strobe
);

  instrClassT cls;
  logic isCall;
  logic isRet;
  logic isRetCall;
  logic callToNext;

  assign cls        = instrClassT'(decClass);
  assign callToNext = (decTarget == decPc + ADDR_W'(4));

  always_comb begin
    isCall    = 1'b0;
    isRet     = 1'b0;
    isRetCall = 1'b0;
    if (decValid) begin
      unique case (cls)
        CLS_CALL:    isCall    = !callToNext;
        CLS_RET:     isRet     = 1'b1;
        CLS_RETCALL: isRetCall = 1'b1;
        default:     ;
      endcase
    end
  end

  // A rewind wins over any decode-driven stack change in the same cycle.
  assign strobe.restore = rsvMispredict;
  assign strobe.push    = !rsvMispredict && (isCall || isRetCall);
  assign strobe.pop     = !rsvMispredict && (isRet || isRetCall);
  // Learning return sites is independent of the rewind.
  assign strobe.learn   = (isRet || isRetCall) && !decTblHit;

endmodule

// File: rtl/rasDatapath.sv
module rasDatapath
  import rasPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DEPTH       = 8,
  parameter int TBL_ENTRIES = 16,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int IDX_W      = $clog2(TBL_ENTRIES),
  localparam int TAG_W      = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  stackStrobeT       strobe,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [ADDR_W-1:0] decPc,
  input  logic [PTR_W-1:0]  rsvPtr,
  input  logic [CNT_W-1:0]  rsvCount,
  output logic              decTblHit,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic [PTR_W-1:0]  predPtr,
  output logic [CNT_W-1:0]  predCount
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  tosPtr, nextPtr, ptrInc, ptrDec, wrIdx;
  logic [CNT_W-1:0]  liveCnt, nextCnt;
  logic              wrEn;
  logic [ADDR_W-1:0] pushVal;
  logic [ADDR_W-1:0] stackMem [DEPTH];

  logic              tblValid [TBL_ENTRIES];
  logic [TAG_W-1:0]  tblTag   [TBL_ENTRIES];
  logic [IDX_W-1:0]  fetchIdx, decIdx;
  logic [TAG_W-1:0]  fetchTag, decTag;
  logic              fetchHit;
  logic              unusedLowBits;

  assign unusedLowBits = ^{fetchPc[1:0], decPc[1:0]};

  // ---------------- stack pointer and count ----------------
  assign ptrInc  = (tosPtr == LAST_PTR) ? '0 : tosPtr + 1'b1;
  assign ptrDec  = (tosPtr == '0) ? LAST_PTR : tosPtr - 1'b1;
  assign pushVal = decPc + ADDR_W'(4);

  always_comb begin
    nextPtr = tosPtr;
    nextCnt = liveCnt;
    wrEn    = 1'b0;
    wrIdx   = ptrInc;
    if (strobe.restore) begin
      nextPtr = rsvPtr;
      nextCnt = (rsvCount > FULL_CNT) ? FULL_CNT : rsvCount;
    end else begin
      unique case ({strobe.push, strobe.pop})
        2'b10: begin
          nextPtr = ptrInc;
          wrEn    = 1'b1;
          wrIdx   = ptrInc;
          nextCnt = (liveCnt == FULL_CNT) ? FULL_CNT : liveCnt + 1'b1;
        end
        2'b01: begin
          nextPtr = ptrDec;
          nextCnt = (liveCnt == '0) ? '0 : liveCnt - 1'b1;
        end
        2'b11: begin
          // pop first, then push: the top slot is rewritten in place
          wrEn    = 1'b1;
          wrIdx   = tosPtr;
          nextCnt = (liveCnt == '0) ? CNT_W'(1) : liveCnt;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tosPtr  <= '0;
      liveCnt <= '0;
    end else begin
      tosPtr  <= nextPtr;
      liveCnt <= nextCnt;
    end
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : gSlot
      always_ff @(posedge clk) begin
        if (wrEn && (wrIdx == PTR_W'(s))) stackMem[s] <= pushVal;
      end
    end
  endgenerate

  // ---------------- return-site table ----------------
  assign fetchIdx = fetchPc[IDX_W+1:2];
  assign fetchTag = fetchPc[ADDR_W-1:IDX_W+2];
  assign decIdx   = decPc[IDX_W+1:2];
  assign decTag   = decPc[ADDR_W-1:IDX_W+2];

  generate
    for (genvar e = 0; e < TBL_ENTRIES; e++) begin : gEntry
      always_ff @(posedge clk) begin
        if (rst)                                        tblValid[e] <= 1'b0;
        else if (strobe.learn && decIdx == IDX_W'(e))   tblValid[e] <= 1'b1;
      end
      always_ff @(posedge clk) begin
        if (strobe.learn && decIdx == IDX_W'(e)) tblTag[e] <= decTag;
      end
    end
  endgenerate

  assign fetchHit  = tblValid[fetchIdx] && (tblTag[fetchIdx] == fetchTag);
  assign decTblHit = tblValid[decIdx] && (tblTag[decIdx] == decTag);

  // ---------------- fetch-cycle outputs ----------------
  assign predValid  = fetchHit && (liveCnt != '0);
  assign predTarget = stackMem[tosPtr];
  assign predPtr    = tosPtr;
  assign predCount  = liveCnt;

endmodule

// File: rtl/retStackPredictor.sv
module retStackPredictor
  import rasPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DEPTH       = 8,
  parameter int TBL_ENTRIES = 16,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              decValid,
  input  logic [2:0]        decClass,
  input  logic [ADDR_W-1:0] decPc,
  input  logic [ADDR_W-1:0] decTarget,
  input  logic              rsvMispredict,
  input  logic [PTR_W-1:0]  rsvPtr,
  input  logic [CNT_W-1:0]  rsvCount,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic [PTR_W-1:0]  predPtr,
  output logic [CNT_W-1:0]  predCount
);

  stackStrobeT strobe;
  logic        decTblHit;

  rasCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .decValid      (decValid),
    .decClass      (decClass),
    .decPc         (decPc),
    .decTarget     (decTarget),
    .rsvMispredict (rsvMispredict),
    .decTblHit     (decTblHit),
    .strobe        (strobe)
  );

  rasDatapath #(
    .ADDR_W      (ADDR_W),
    .DEPTH       (DEPTH),
    .TBL_ENTRIES (TBL_ENTRIES)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .fetchPc    (fetchPc),
    .decPc      (decPc),
    .rsvPtr     (rsvPtr),
    .rsvCount   (rsvCount),
    .decTblHit  (decTblHit),
    .predValid  (predValid),
    .predTarget (predTarget),
    .predPtr    (predPtr),
    .predCount  (predCount)
  );

endmodule

// File: rtl/rasChecker.sv
module rasChecker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              decValid,
  input logic [2:0]        decClass,
  input logic [ADDR_W-1:0] decPc,
  input logic [ADDR_W-1:0] decTarget,
  input logic              rsvMispredict,
  input logic [PTR_W-1:0]  rsvPtr,
  input logic [CNT_W-1:0]  rsvCount,
  input logic              predValid,
  input logic [PTR_W-1:0]  predPtr,
  input logic [CNT_W-1:0]  predCount
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (predCount == '0 && predPtr == '0 && !predValid));

  assert_push_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (decValid && decClass == 3'd1 && decTarget != decPc + ADDR_W'(4) && !rsvMispredict)
      |=> predPtr == PTR_W'($past(predPtr) + 1'b1));

  assert_linkbr_inert_R5: assert property (@(posedge clk) disable iff (rst)
    (decValid && decClass == 3'd3 && !rsvMispredict)
      |=> ($stable(predPtr) && $stable(predCount)));

  assert_call_next_inert_R6: assert property (@(posedge clk) disable iff (rst)
    (decValid && decClass == 3'd1 && decTarget == decPc + ADDR_W'(4) && !rsvMispredict)
      |=> ($stable(predPtr) && $stable(predCount)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    predCount <= FULL_CNT);

  assert_underflow_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (decValid && decClass == 3'd2 && predCount == '0 && !rsvMispredict)
      |=> (predCount == '0 && !predValid));

  assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
    rsvMispredict |=> (predPtr == $past(rsvPtr) &&
      predCount == (($past(rsvCount) > FULL_CNT) ? FULL_CNT : $past(rsvCount))));

endmodule

bind retStackPredictor rasChecker #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH),
  .PTR_W  (PTR_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .decValid      (decValid),
  .decClass      (decClass),
  .decPc         (decPc),
  .decTarget     (decTarget),
  .rsvMispredict (rsvMispredict),
  .rsvPtr        (rsvPtr),
  .rsvCount      (rsvCount),
  .predValid     (predValid),
  .predPtr       (predPtr),
  .predCount     (predCount)
);

// File: tb/retStackPredictor_tb_top.sv
module retStackPredictor_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        pv;
    logic [31:0] tgt;
    logic [2:0]  ptr;
    logic [3:0]  cnt;
  } expT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchPc = '0;
  logic        decValid = 1'b0;
  logic [2:0]  decClass = '0;
  logic [31:0] decPc = '0;
  logic [31:0] decTarget = '0;
  logic        rsvMispredict = 1'b0;
  logic [2:0]  rsvPtr = '0;
  logic [3:0]  rsvCount = '0;
  logic        predValid;
  logic [31:0] predTarget;
  logic [2:0]  predPtr;
  logic [3:0]  predCount;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  expT   expQ[$];
  string reqQ[$];

  // independent reference state
  logic [31:0] mStack [8];
  logic [2:0]  mPtr = '0;
  logic [3:0]  mCnt = '0;
  logic        tV [16];
  logic [25:0] tT [16];
  logic [2:0]  sPtr;
  logic [3:0]  sCnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  retStackPredictor dut_i (
    .clk           (clk),
    .rst           (rst),
    .fetchPc       (fetchPc),
    .decValid      (decValid),
    .decClass      (decClass),
    .decPc         (decPc),
    .decTarget     (decTarget),
    .rsvMispredict (rsvMispredict),
    .rsvPtr        (rsvPtr),
    .rsvCount      (rsvCount),
    .predValid     (predValid),
    .predTarget    (predTarget),
    .predPtr       (predPtr),
    .predCount     (predCount)
  );

  task automatic step(input logic [31:0] fpc, input logic dv, input logic [2:0] cls,
                      input logic [31:0] pc, input logic [31:0] tgt, input logic mis,
                      input logic [2:0] rp, input logic [3:0] rc, input string req);
    expT e;
    logic hitF, hitD, doPush, doPop;
    @(negedge clk);
    fetchPc = fpc; decValid = dv; decClass = cls; decPc = pc; decTarget = tgt;
    rsvMispredict = mis; rsvPtr = rp; rsvCount = rc;
    hitF  = tV[fpc[5:2]] && (tT[fpc[5:2]] == fpc[31:6]);
    e.pv  = hitF && (mCnt != 0);
    e.tgt = mStack[mPtr];
    e.ptr = mPtr;
    e.cnt = mCnt;
    expQ.push_back(e);
    reqQ.push_back(req);
    // reference update for the coming edge
    hitD   = tV[pc[5:2]] && (tT[pc[5:2]] == pc[31:6]);
    doPop  = dv && (cls == 3'd2 || cls == 3'd4);
    doPush = dv && ((cls == 3'd1 && tgt != pc + 32'd4) || cls == 3'd4);
    if (doPop && !hitD) begin
      tV[pc[5:2]] = 1'b1;
      tT[pc[5:2]] = pc[31:6];
    end
    if (mis) begin
      mPtr = rp;
      mCnt = (rc > 4'd8) ? 4'd8 : rc;
    end else begin
      if (doPop) begin
        mPtr = mPtr - 3'd1;
        mCnt = (mCnt == 0) ? 4'd0 : mCnt - 4'd1;
      end
      if (doPush) begin
        mPtr = mPtr + 3'd1;
        mStack[mPtr] = pc + 32'd4;
        mCnt = (mCnt == 4'd8) ? 4'd8 : mCnt + 4'd1;
      end
    end
  endtask

  task automatic idle(input logic [31:0] fpc, input string req);
    step(fpc, 1'b0, 3'd0, 32'h0, 32'h0, 1'b0, 3'd0, 4'd0, req);
  endtask

  // monitor: compares each expected item against the outputs of that cycle
  always begin
    @(negedge clk);
    #2;
    if (expQ.size() > 0) begin
      expT   e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      vectors++;
      if (predValid !== e.pv || predPtr !== e.ptr || predCount !== e.cnt ||
          (e.pv && predTarget !== e.tgt)) begin
        miscompares++;
        $display("FAIL %s: got pv=%b ptr=%0d cnt=%0d tgt=%h, expected pv=%b ptr=%0d cnt=%0d tgt=%h",
                 r, predValid, predPtr, predCount, predTarget, e.pv, e.ptr, e.cnt, e.tgt);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mStack[i] = '0;
    for (int i = 0; i < 16; i++) begin tV[i] = 1'b0; tT[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    idle(32'h3040, "R1");                                 // reset state
    step(32'h3040, 1, 3'd1, 32'h100, 32'h800, 0, 0, 0, "R2");
    idle(32'h3040, "R2");                                 // pushed, table still empty
    step(32'h3040, 1, 3'd2, 32'h3040, 0, 0, 0, 0, "R3");  // pop, learn 0x3040
    idle(32'h3040, "R8");                                 // hit but empty stack
    step(32'h3040, 1, 3'd1, 32'h200, 32'h900, 0, 0, 0, "R2");
    idle(32'h3040, "R4");                                 // predicts 0x204
    step(32'h3040, 1, 3'd1, 32'h300, 32'ha00, 0, 0, 0, "R2");
    idle(32'h3040, "R3");                                 // predicts 0x304
    step(32'h3040, 1, 3'd2, 32'h3040, 0, 0, 0, 0, "R3");
    idle(32'h3040, "R3");                                 // LIFO: back to 0x204
    step(32'h3080, 1, 3'd3, 32'h3080, 32'h204, 0, 0, 0, "R5");
    idle(32'h3080, "R5");                                 // link branch not learned
    idle(32'h3040, "R5");                                 // stack untouched
    step(32'h3040, 1, 3'd1, 32'h400, 32'h404, 0, 0, 0, "R6");
    idle(32'h3040, "R6");                                 // call-to-next: no push
    step(32'h3040, 1, 3'd2, 32'h7040, 0, 0, 0, 0, "R4");  // alias replaces 0x3040
    idle(32'h3040, "R4");
    step(32'h7040, 1, 3'd1, 32'h500, 32'h900, 0, 0, 0, "R4");
    idle(32'h7040, "R4");                                 // predicts 0x504

    for (int i = 0; i < 9; i++)
      step(32'h7040, 1, 3'd1, 32'h1000 + 32'(i * 16), 32'h8000, 0, 0, 0, "R7");
    idle(32'h7040, "R7");                                 // count saturated, wrapped
    for (int i = 0; i < 8; i++) begin
      step(32'h7040, 1, 3'd2, 32'h7040, 0, 0, 0, 0, "R7");
      idle(32'h7040, "R7");
    end
    step(32'h7040, 1, 3'd2, 32'h7040, 0, 0, 0, 0, "R8");  // underflow
    idle(32'h7040, "R8");
    step(32'h7040, 1, 3'd1, 32'h600, 32'h900, 0, 0, 0, "R8");
    idle(32'h7040, "R8");                                 // valid again

    step(32'h7040, 1, 3'd1, 32'h610, 32'h900, 0, 0, 0, "R9");
    sPtr = mPtr; sCnt = mCnt;
    step(32'h7040, 1, 3'd1, 32'h620, 32'h900, 0, 0, 0, "R9");
    step(32'h7040, 1, 3'd1, 32'h630, 32'h900, 1, sPtr, sCnt, "R9");
    idle(32'h7040, "R9");                                 // rewound, call ignored
    step(32'h7040, 0, 3'd0, 0, 0, 1, 3'd5, 4'd15, "R9");  // oversize count clamps
    idle(32'h7040, "R9");
    step(32'h7040, 0, 3'd0, 0, 0, 1, sPtr, sCnt, "R9");

    step(32'h6048, 1, 3'd4, 32'h6048, 32'h900, 0, 0, 0, "R10");
    idle(32'h6048, "R10");                                // top replaced, learned
    step(32'h6048, 0, 3'd0, 0, 0, 1, 3'd2, 4'd0, "R10");
    idle(32'h6048, "R10");
    step(32'h6048, 1, 3'd4, 32'h6048, 32'h900, 0, 0, 0, "R10");
    idle(32'h6048, "R10");                                // count 0 -> 1

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule